// File: doc/BRIEF.md
# Spatial Dither Gray Interpolator

This block lets a column driver with only a few coarse drive levels show finer gray steps. Each incoming fine gray code is split into a coarse level index and a two-bit remainder. Pixels are grouped in 2x2 tiles. Inside each tile, the pixels either stay on the coarse level or move up to the next coarse level. The pixels chosen to move up are picked by their row and column parity, so that the average of the tile equals the requested fine gray.

The pixel stream arrives at one pixel per clock. Each pixel is qualified by a valid strobe and carries its row and column parity bits. The block returns the coarse level index for each pixel one clock later, together with a matching valid. When the coarse index is already at the top level, the upward choice is clamped, so the output never wraps to a low level. The cost of the method is spatial resolution: a fine level is only reproduced as the average over a tile.

Top module: `dither_interp`

## Requirements
- R1: While rst_n is low, and after its release until the first valid pixel, out_valid is 0 and out_level is 0.
- R2: out_valid equals the in_valid of the previous clock. A pixel presented with in_valid high appears on out_level on the next clock.
- R3: The fine code splits into a coarse index, in_gray[GRAY_W-1:2], and a remainder, in_gray[1:0]. With a remainder of 0, every position outputs the coarse index.
- R4: The tile position maps to a rank by the pair (in_row_odd, in_col_odd): (0,0) has rank 0, (1,1) rank 1, (0,1) rank 2 and (1,0) rank 3. A position outputs coarse+1 exactly when its rank is below the remainder.
- R5: Below the top coarse level, the four outputs of one tile for the same fine code sum to the fine code. This means exactly remainder-many positions take the upper level.
- R6: When the coarse index equals the top level (all ones), every position outputs the top level whatever the remainder.
- R7: A clock with in_valid low leaves out_level unchanged and drives out_valid to 0.
- R8: With a remainder of 3, only the rank-3 position (row odd, column even) stays on the coarse index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel strobe |
| in_gray | input | GRAY_W | Fine gray code of the pixel |
| in_row_odd | input | 1 | Row parity of the pixel |
| in_col_odd | input | 1 | Column parity of the pixel |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_level | output | GRAY_W-2 | Coarse level index chosen for the pixel |

## Verification
The bench goes after the rank table position by position. A swapped entry in the order matrix sends the wrong pixel up: a tile still averages correctly, but a single-position check fails. The tile-sum check catches a comparison written as "at most" instead of "below", because that design lifts one pixel too many and overshoots the fine code by a quarter of a coarse step. Codes at the top coarse level expose a missing clamp, since that design wraps to level zero. Idle clocks between pixels expose an output register that loads without its valid enable.

// File: rtl/dith_pkg.sv
package dith_pkg;
  localparam int RANK_W = 2;

  typedef struct packed {
    logic row_odd;
    logic col_odd;
  } tile_pos_t;

  typedef logic [RANK_W-1:0] rank_t;
endpackage

// File: rtl/dith_rank.sv
module dith_rank
  import dith_pkg::*;
(
  input  tile_pos_t pos,
  output rank_t     rank
);
  // order matrix: row even -> 0,2 ; row odd -> 3,1
  always_comb begin
    unique case ({pos.row_odd, pos.col_odd})
      2'b00:   rank = 2'd0;
      2'b01:   rank = 2'd2;
      2'b10:   rank = 2'd3;
      default: rank = 2'd1;
    endcase
  end
endmodule

// File: rtl/dith_level_sel.sv
module dith_level_sel
  import dith_pkg::*;
#(
  parameter int GRAY_W = 6
) (
  input  logic [GRAY_W-1:0] gray,
  input  rank_t             rank,
  output logic [GRAY_W-3:0] level
);
  localparam int LVL_W = GRAY_W - 2;
  localparam logic [LVL_W-1:0] LVL_TOP = '1;

  logic [LVL_W-1:0]  coarse;
  logic [RANK_W-1:0] rem;
  logic              lift;
  logic              at_top;

  always_comb begin
    coarse = gray[GRAY_W-1:RANK_W];
    rem    = gray[RANK_W-1:0];
    lift   = (rank < rem);
    at_top = (coarse == LVL_TOP);
    if (lift && !at_top) level = coarse + 1'b1;
    else                 level = coarse;
  end
endmodule

// File: rtl/dith_out_reg.sv
module dith_out_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         vld_q,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         vld_nxt;

  always_comb begin
    vld_nxt = load;
    q_nxt   = q;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      q     <= '0;
    end else begin
      vld_q <= vld_nxt;
      q     <= q_nxt;
    end
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/dither_interp.sv
module dither_interp
  import dith_pkg::*;
#(
  parameter int GRAY_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [GRAY_W-1:0] in_gray,
  input  logic              in_row_odd,
  input  logic              in_col_odd,
  output logic              out_valid,
  output logic [GRAY_W-3:0] out_level
);
  localparam int LVL_W = GRAY_W - 2;
  localparam logic [LVL_W-1:0] LVL_TOP = '1;

  tile_pos_t        pos;
  rank_t            rank;
  logic [LVL_W-1:0] level_d;

  assign pos.row_odd = in_row_odd;
  assign pos.col_odd = in_col_odd;

  dith_rank u_rank (
    .pos  (pos),
    .rank (rank)
  );

  dith_level_sel #(.GRAY_W(GRAY_W)) u_sel (
    .gray  (in_gray),
    .rank  (rank),
    .level (level_d)
  );

  dith_out_reg #(.W(LVL_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_valid),
    .d     (level_d),
    .vld_q (out_valid),
    .q     (out_level)
  );

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3
  zero_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_gray[1:0] == 2'd0) |=> out_level == $past(in_gray[GRAY_W-1:2]));

  // R6
  top_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_gray[GRAY_W-1:2] == LVL_TOP) |=> out_level == LVL_TOP);

  // R4
  rank0_lift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_row_odd && !in_col_odd && in_gray[1:0] != 2'd0
     && in_gray[GRAY_W-1:2] != LVL_TOP)
    |=> out_level == $past(in_gray[GRAY_W-1:2]) + 1'b1);

  // R8
  rank3_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_row_odd && !in_col_odd)
    |=> out_level == $past(in_gray[GRAY_W-1:2]));
endmodule

// File: tb/sim_dither_interp.sv
module sim_dither_interp;
  localparam int CLK_PERIOD = 10;
  localparam int GRAY_W     = 6;
  localparam int LVL_W      = GRAY_W - 2;
  localparam int LVL_TOP    = (1 << LVL_W) - 1;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [GRAY_W-1:0] in_gray;
  logic              in_row_odd;
  logic              in_col_odd;
  logic              out_valid;
  logic [LVL_W-1:0]  out_level;

  int n_chk;
  int n_fail;

  dither_interp #(.GRAY_W(GRAY_W)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_gray    (in_gray),
    .in_row_odd (in_row_odd),
    .in_col_odd (in_col_odd),
    .out_valid  (out_valid),
    .out_level  (out_level)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int rank_of(input int r, input int c);
    if (r == 0 && c == 0) return 0;
    if (r == 1 && c == 1) return 1;
    if (r == 0 && c == 1) return 2;
    return 3;
  endfunction

  function automatic int exp_level(input int g, input int r, input int c);
    int cs = g / 4;
    int rm = g % 4;
    if (rank_of(r, c) < rm && cs < LVL_TOP) return cs + 1;
    return cs;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, result sampled at the following negedge
  task automatic send(input int g, input int r, input int c, output int lvl);
    in_valid   = 1'b1;
    in_gray    = GRAY_W'(g);
    in_row_odd = r[0];
    in_col_odd = c[0];
    @(negedge clk);
    check("R2 valid", int'(out_valid), 1);
    lvl = int'(out_level);
    in_valid = 1'b0;
  endtask

  task automatic idle_check(input int g, input int last);
    in_valid   = 1'b0;
    in_gray    = GRAY_W'(g);
    in_row_odd = g[0];
    in_col_odd = g[1];
    @(negedge clk);
    check("R7 valid low", int'(out_valid), 0);
    check("R7 level held", int'(out_level), last);
  endtask

  initial begin
    int seed;
    int lvl;
    int sum;
    n_chk = 0; n_fail = 0;
    seed = $urandom(32'd2024);
    rst_n = 1'b0; in_valid = 1'b0; in_gray = '0; in_row_odd = 1'b0; in_col_odd = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset level", int'(out_level), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release valid", int'(out_valid), 0);
    check("R1 after release level", int'(out_level), 0);

    // fine codes 48..52 span one coarse step: per-position and tile sum
    for (int g = 48; g <= 52; g++) begin
      sum = 0;
      for (int p = 0; p < 4; p++) begin
        send(g, p / 2, p % 2, lvl);
        check(g % 4 == 0 ? "R3 zero remainder" : "R4 rank order", lvl, exp_level(g, p / 2, p % 2));
        sum += lvl;
      end
      check("R5 tile sum", sum, g);
    end

    // remainder 3: only row odd / column even stays low
    for (int p = 0; p < 4; p++) begin
      send(23, p / 2, p % 2, lvl);
      check("R8 remainder three", lvl, (p == 2) ? 5 : 6);
    end

    // top coarse level clamps
    for (int g = 60; g < 64; g++) begin
      for (int p = 0; p < 4; p++) begin
        send(g, p / 2, p % 2, lvl);
        check("R6 clamp", lvl, LVL_TOP);
      end
    end

    // back-to-back stream then idle cycles
    in_valid = 1'b1; in_gray = 6'd9; in_row_odd = 1'b0; in_col_odd = 1'b0;
    @(negedge clk);
    check("R2 stream 1", int'(out_level), 3);
    in_gray = 6'd9; in_row_odd = 1'b1; in_col_odd = 1'b1;
    @(negedge clk);
    check("R2 stream 2", int'(out_level), 2);
    idle_check(63, 2);
    idle_check(1, 2);

    // random stream with fixed seed
    for (int i = 0; i < 400; i++) begin
      int g = int'($urandom_range(63, 0));
      int r = int'($urandom_range(1, 0));
      int c = int'($urandom_range(1, 0));
      send(g, r, c, lvl);
      check("R4 random", lvl, exp_level(g, r, c));
      if ($urandom_range(3, 0) == 0) idle_check(int'($urandom_range(63, 0)), lvl);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule